// File: doc/BRIEF.md
# Test-Mode Instruction Injection Controller

This block is the test-mode glue around a small 4-bit processor core. Two dedicated test pins are decoded into four one-hot modes. One mode is normal operation and three are test modes. Two of the test modes are observation modes. In them the 4-bit output port shows the accumulator or one nibble of the program counter in place of the port's usual data. The third test mode is the injection mode. In it, each instruction byte handed to the instruction decoder is built from two nibbles taken from the 4-bit input port on two successive clocks, and the program ROM is not read.

The mode pins are decoded combinationally, so the byte source can change between any two bytes. One possible sequence injects the opcode byte of a two-byte instruction, then returns the pins to normal so that the operand byte comes from ROM. While the port's direction bit marks the port as an input, no observed value leaves the block. That bit comes from the core, and the core sets it to input at reset.

Top module: `tm_inject_ctrl`

## Requirements
- R1: `test_pins` selects the mode: 2'b00 normal, 2'b01 accumulator view, 2'b10 program-counter view, 2'b11 injection. In normal mode `port_out` equals `norm_out`, `instr_byte` equals `rom_byte` and `byte_valid` is 1.
- R2: In accumulator view with `port_is_out`=1, `port_out` equals `acc_val`.
- R3: In program-counter view with `port_is_out`=1, `port_out` shows one nibble of `pc_val` chosen by `pc_nib_sel`: 0 gives bits [3:0], 1 gives bits [7:4], 2 gives bits [11:8], and 3 gives 4'h0.
- R4: While `port_is_out`=0, `port_out` is 4'h0 in every mode.
- R5: In injection mode, the first clock edge in the mode captures `in_port` as the first nibble and the next edge captures the second nibble. With the default order the first nibble becomes bits [7:4] of `instr_byte`. The byte is presented from the second edge onward.
- R6: In injection mode, `byte_valid` is high for exactly the one cycle after each second-nibble edge and low in all other cycles.
- R7: Entering or leaving injection mode returns the nibble phase to the first nibble. A half-loaded byte is dropped, and after re-entry the next edge captures a first nibble again.
- R8: Once an injected byte has been presented, switching the pins to normal mode makes `instr_byte` equal `rom_byte` with `byte_valid`=1 at once, so the bytes of one instruction can come from mixed sources.
- R9: While `rst_n` is low at a clock edge, the nibble phase, the held nibble and the assembled byte are cleared. In injection mode after reset, `instr_byte` is 8'h00 and `byte_valid` is 0.
- R10: In injection mode with `port_is_out`=1, `port_out` equals `norm_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| test_pins | input | 2 | Test-mode pins; bit 0 is the low bit of the mode code |
| in_port | input | 4 | 4-bit input port register, source of injected nibbles |
| rom_byte | input | 8 | Byte read from program ROM |
| acc_val | input | 4 | Accumulator value from the core |
| pc_val | input | 12 | Program counter from the core |
| pc_nib_sel | input | 2 | Nibble of the program counter shown in program-counter view |
| norm_out | input | 4 | Normal data the core writes to the output port |
| port_is_out | input | 1 | Direction bit: 1 when the port is an output |
| instr_byte | output | 8 | Instruction byte to the decoder |
| byte_valid | output | 1 | Byte is valid: always high for ROM bytes, a one-cycle strobe for injected bytes |
| port_out | output | 4 | 4-bit output port |

## Verification
The assertions check the following on every cycle: the mode decode is one-hot, the port stays quiet while it is an input, the injection strobe never lasts two cycles, the phase returns to the first nibble outside injection mode, and every strobe follows a second-nibble capture. Only the bench's scenarios can show the rest. These are the nibble order and the value of an assembled byte, a half-loaded byte being dropped when the pins change, the byte-by-byte hand-back to ROM, and the nibble chosen for each program-counter select value.

// File: rtl/tm_inject_pkg.sv
// Shared definitions for the test-mode injection controller.
// Assumes the mode code is the pin pair read as {pin1, pin0}.
package tm_inject_pkg;
    typedef enum logic [1:0] {
        TM_NORMAL  = 2'd0,
        TM_OBS_ACC = 2'd1,
        TM_OBS_PC  = 2'd2,
        TM_INJECT  = 2'd3
    } tm_mode_e;

    localparam int TM_PIN_W = 2;
    localparam int TM_MODES = 1 << TM_PIN_W;
endpackage

// File: rtl/tm_mode_decode.sv
// Decodes the test pins into a one-hot mode vector. Each pin is inverted and
// every mode term ANDs either the true or the inverted level of each pin.
// Assumes pins are already synchronous to clk.
module tm_mode_decode
    import tm_inject_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TM_PIN_W-1:0] pins,
    output logic [TM_MODES-1:0] mode_vec
);
    logic [TM_PIN_W-1:0] pin_n;

    // Inverted copies of the pins.
    assign pin_n = ~pins;

    // One AND term per mode code.
    for (genvar m = 0; m < TM_MODES; m++) begin : g_term
        logic [TM_PIN_W-1:0] lit;
        for (genvar b = 0; b < TM_PIN_W; b++) begin : g_lit
            localparam bit WANT = ((m >> b) & 1) == 1;
            assign lit[b] = WANT ? pins[b] : pin_n[b];
        end
        assign mode_vec[m] = &lit;
    end

    assert_mode_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(mode_vec));
endmodule

// File: rtl/tm_nibble_asm.sv
// Assembles one instruction byte from two nibbles over two clock edges while
// injection is enabled. A one-cycle strobe marks each completed byte. The phase
// is held at the first nibble whenever injection is disabled.
// HI_FIRST=1 puts the first nibble in the upper half of the byte.
module tm_nibble_asm #(
    parameter int NIB_W    = 4,
    parameter bit HI_FIRST = 1'b1,
    localparam int BYTE_W  = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inject_en,
    input  logic [NIB_W-1:0]  nib_in,
    output logic [BYTE_W-1:0] asm_byte,
    output logic              asm_valid
);
    logic              second_ph;
    logic [NIB_W-1:0]  held_nib;
    logic [BYTE_W-1:0] joined;

    // Order of the two nibbles inside the byte.
    if (HI_FIRST) begin : g_hi_first
        assign joined = {held_nib, nib_in};
    end else begin : g_lo_first
        assign joined = {nib_in, held_nib};
    end

    // Phase, nibble holding and byte assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            second_ph <= 1'b0;
            held_nib  <= '0;
            asm_byte  <= '0;
            asm_valid <= 1'b0;
        end else if (!inject_en) begin
            second_ph <= 1'b0;
            asm_valid <= 1'b0;
        end else if (!second_ph) begin
            held_nib  <= nib_in;
            second_ph <= 1'b1;
            asm_valid <= 1'b0;
        end else begin
            asm_byte  <= joined;
            asm_valid <= 1'b1;
            second_ph <= 1'b0;
        end
    end

    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        asm_valid |=> !asm_valid);
    assert_phase_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !inject_en |=> !second_ph);
    assert_strobe_after_second_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asm_valid) |-> $past(second_ph) && $past(inject_en));
endmodule

// File: rtl/tm_port_observe.sv
// Drives the output port: normal data, the accumulator, or one nibble of the
// program counter, as the mode selects. The port is forced quiet while its
// direction bit marks it as an input. Select values past the last nibble give 0.
module tm_port_observe
    import tm_inject_pkg::*;
#(
    parameter int NIB_W = 4,
    parameter int PC_W  = 12,
    parameter int SEL_W = 2,
    localparam int PC_NIBS = PC_W / NIB_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TM_MODES-1:0] mode_vec,
    input  logic [NIB_W-1:0]    norm_out,
    input  logic [NIB_W-1:0]    acc_val,
    input  logic [PC_W-1:0]     pc_val,
    input  logic [SEL_W-1:0]    pc_nib_sel,
    input  logic                port_is_out,
    output logic [NIB_W-1:0]    port_out
);
    logic [NIB_W-1:0] pc_nib [PC_NIBS];
    logic [NIB_W-1:0] pc_pick;
    logic [NIB_W-1:0] chosen;

    // Split the program counter into nibbles.
    for (genvar n = 0; n < PC_NIBS; n++) begin : g_nib
        assign pc_nib[n] = pc_val[n*NIB_W +: NIB_W];
    end

    // Pick the requested program-counter nibble.
    always_comb begin
        pc_pick = '0;
        for (int n = 0; n < PC_NIBS; n++) begin
            if (int'(pc_nib_sel) == n) pc_pick = pc_nib[n];
        end
    end

    // Mode multiplexer and direction gate.
    always_comb begin
        if (mode_vec[int'(TM_OBS_ACC)])     chosen = acc_val;
        else if (mode_vec[int'(TM_OBS_PC)]) chosen = pc_pick;
        else                                chosen = norm_out;
        port_out = port_is_out ? chosen : '0;
    end

    assert_port_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !port_is_out |-> port_out == '0);
    assert_acc_view_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_vec[int'(TM_OBS_ACC)] && port_is_out) |-> port_out == acc_val);
endmodule

// File: rtl/tm_inject_ctrl.sv
// Top of the test-mode controller. Decodes the test pins, selects the
// instruction byte source (ROM or assembled nibbles) and drives the observation
// port. Assumes rom_byte is valid in every cycle the core fetches from ROM.
module tm_inject_ctrl
    import tm_inject_pkg::*;
#(
    parameter int NIB_W    = 4,
    parameter int PC_W     = 12,
    parameter int SEL_W    = 2,
    parameter bit HI_FIRST = 1'b1,
    localparam int BYTE_W  = 2 * NIB_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TM_PIN_W-1:0] test_pins,
    input  logic [NIB_W-1:0]    in_port,
    input  logic [BYTE_W-1:0]   rom_byte,
    input  logic [NIB_W-1:0]    acc_val,
    input  logic [PC_W-1:0]     pc_val,
    input  logic [SEL_W-1:0]    pc_nib_sel,
    input  logic [NIB_W-1:0]    norm_out,
    input  logic                port_is_out,
    output logic [BYTE_W-1:0]   instr_byte,
    output logic                byte_valid,
    output logic [NIB_W-1:0]    port_out
);
    logic [TM_MODES-1:0] mode_vec;
    logic                inject_en;
    logic [BYTE_W-1:0]   asm_byte;
    logic                asm_valid;

    tm_mode_decode u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins     (test_pins),
        .mode_vec (mode_vec)
    );

    assign inject_en = mode_vec[int'(TM_INJECT)];

    tm_nibble_asm #(.NIB_W(NIB_W), .HI_FIRST(HI_FIRST)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .inject_en (inject_en),
        .nib_in    (in_port),
        .asm_byte  (asm_byte),
        .asm_valid (asm_valid)
    );

    tm_port_observe #(.NIB_W(NIB_W), .PC_W(PC_W), .SEL_W(SEL_W)) u_obs (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_vec    (mode_vec),
        .norm_out    (norm_out),
        .acc_val     (acc_val),
        .pc_val      (pc_val),
        .pc_nib_sel  (pc_nib_sel),
        .port_is_out (port_is_out),
        .port_out    (port_out)
    );

    // Byte source selection for the instruction decoder.
    always_comb begin
        if (inject_en) begin
            instr_byte = asm_byte;
            byte_valid = asm_valid;
        end else begin
            instr_byte = rom_byte;
            byte_valid = 1'b1;
        end
    end

    assert_rom_handback_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (test_pins == 2'b00) |-> (byte_valid && instr_byte == rom_byte));
endmodule

// File: tb/tm_inject_ctrl_bench.sv
module tm_inject_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] test_pins = 2'b00;
    logic [3:0] in_port = '0;
    logic [7:0] rom_byte = 8'h00;
    logic [3:0] acc_val = '0;
    logic [11:0] pc_val = '0;
    logic [1:0] pc_nib_sel = '0;
    logic [3:0] norm_out = '0;
    logic       port_is_out = 1'b0;
    logic [7:0] instr_byte;
    logic       byte_valid;
    logic [3:0] port_out;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    tm_inject_ctrl u_tm_inject_ctrl (
        .clk(clk), .rst_n(rst_n), .test_pins(test_pins), .in_port(in_port),
        .rom_byte(rom_byte), .acc_val(acc_val), .pc_val(pc_val),
        .pc_nib_sel(pc_nib_sel), .norm_out(norm_out), .port_is_out(port_is_out),
        .instr_byte(instr_byte), .byte_valid(byte_valid), .port_out(port_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock edge, then settle away from the edge.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();   // R9
        test_pins = 2'b11;
        rst_n = 1'b0;
        in_port = 4'hF;
        tick(); tick();
        check("R9 byte", instr_byte, 8'h00);
        check("R9 valid", byte_valid, 1'b0);
        rst_n = 1'b1;
        in_port = 4'h6;
        tick();                 // first nibble after reset
        check("R9 no strobe", byte_valid, 1'b0);
        test_pins = 2'b00;
        tick();
    endtask

    task automatic t_normal();  // R1, R4
        test_pins = 2'b00; rom_byte = 8'h3B; norm_out = 4'h9; port_is_out = 1'b1;
        #1;
        check("R1 rom byte", instr_byte, 8'h3B);
        check("R1 valid", byte_valid, 1'b1);
        check("R1 port", port_out, 4'h9);
        port_is_out = 1'b0;
        #1;
        check("R4 normal quiet", port_out, 4'h0);
    endtask

    task automatic t_observe(); // R2, R3, R4
        port_is_out = 1'b1; acc_val = 4'hD; pc_val = 12'hA5C;
        test_pins = 2'b01; #1;
        check("R2 acc", port_out, 4'hD);
        port_is_out = 1'b0; #1;
        check("R4 acc quiet", port_out, 4'h0);
        port_is_out = 1'b1; test_pins = 2'b10;
        pc_nib_sel = 2'd0; #1; check("R3 sel0", port_out, 4'hC);
        pc_nib_sel = 2'd1; #1; check("R3 sel1", port_out, 4'h5);
        pc_nib_sel = 2'd2; #1; check("R3 sel2", port_out, 4'hA);
        pc_nib_sel = 2'd3; #1; check("R3 sel3", port_out, 4'h0);
        port_is_out = 1'b0; #1; check("R4 pc quiet", port_out, 4'h0);
        test_pins = 2'b00;
    endtask

    task automatic t_inject();  // R5, R6, R10
        port_is_out = 1'b1; norm_out = 4'h2; acc_val = 4'h7;
        test_pins = 2'b11; in_port = 4'hA; #1;
        check("R10 port", port_out, 4'h2);
        tick();
        check("R6 low after first", byte_valid, 1'b0);
        in_port = 4'h5;
        tick();
        check("R5 byte A5", instr_byte, 8'hA5);
        check("R6 strobe", byte_valid, 1'b1);
        in_port = 4'hC;
        tick();
        check("R6 single cycle", byte_valid, 1'b0);
        in_port = 4'h3;
        tick();
        check("R5 byte C3", instr_byte, 8'hC3);
        check("R6 strobe2", byte_valid, 1'b1);
    endtask

    task automatic t_handback(); // R8
        rom_byte = 8'h4E;
        test_pins = 2'b00; #1;
        check("R8 rom byte", instr_byte, 8'h4E);
        check("R8 valid", byte_valid, 1'b1);
        tick();
    endtask

    task automatic t_phase_reset(); // R7
        test_pins = 2'b11; in_port = 4'h9;
        tick();                 // half byte
        test_pins = 2'b00; rom_byte = 8'h11;
        tick();                 // leave: phase cleared
        check("R7 rom while out", instr_byte, 8'h11);
        test_pins = 2'b11; in_port = 4'h2;
        tick();
        check("R7 re-entry no strobe", byte_valid, 1'b0);
        in_port = 4'h7;
        tick();
        check("R7 fresh byte", instr_byte, 8'h27);
        check("R7 strobe", byte_valid, 1'b1);
        test_pins = 2'b00;
        tick();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_normal();
        t_observe();
        t_inject();
        t_handback();
        t_phase_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule